// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Filter

This block receives asynchronous serial characters on a single line and places them in a small holding queue for a host to read. Each character is a start bit, 5 to 8 data bits sent least significant bit first, one extra bit, and a stop bit. In normal mode the extra bit is parity. In multidrop mode it is an address/data tag: a one marks an address character and a zero marks a data character.

In multidrop mode the line is watched all the time. When the receiver is switched off, only address characters get through, so a node can sleep through traffic meant for other nodes and still see its address. When the receiver is on, every character is taken. The tag value is reported in the status slot that carries the parity error in normal mode, and parity is never checked in multidrop mode. Framing, break and overrun reporting work the same way in both modes.

The line is sampled on a tick that runs at 16 times the bit rate. The tick comes from a free-running divider of `TICK_DIV` clocks. The queue holds `FIFO_DEPTH` characters. Its head is always shown on the read outputs, and a pop strobe removes it.

Top module: `mdr_rx_top`

## Requirements
- R1: After reset, `rx_rdy` is 0 and the overrun bit `rd_status[4]` is 0.
- R2: One bit lasts 16 ticks, and one tick lasts `TICK_DIV` clocks. `len_sel` sets the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits arrive least significant bit first, and `rd_data` bits at or above the length read 0.
- R3: Multidrop mode (`mdrop`=1) with `rx_en`=0: a character whose tag is 1 is queued and `rd_status[5]` reads 1.
- R4: Multidrop mode with `rx_en`=0: a character whose tag is 0 is dropped. The queue and `rx_rdy` are unchanged.
- R5: Multidrop mode with `rx_en`=1: every character is queued, and `rd_status[5]` equals the received tag.
- R6: Normal mode (`mdrop`=0): a character is queued only when `rx_en`=1 and is dropped otherwise.
- R7: Normal mode: `rd_status[5]` is 1 when the XOR of the data bits and the parity bit differs from `par_odd`. With `par_odd`=0 the parity is even; with `par_odd`=1 it is odd.
- R8: A stop bit sampled low sets the framing bit `rd_status[6]`. The data and tag are still stored.
- R9: When the data, the tag and the stop bit are all 0, one character is stored with data 0 and both `rd_status[7]` (break) and `rd_status[6]` set. No further character starts until the line has gone high again.
- R10: The queue keeps arrival order. `rx_rdy` is 1 while it holds at least one character. A pop removes the head, and a pop on an empty queue has no effect.
- R11: An accepted character that arrives while the queue is full and no pop is made is discarded. It sets `rd_status[4]`, which stays set until reset.
- R12: A low pulse shorter than half a bit at the mid-start check does not start a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receiver enable |
| mdrop | input | 1 | 1 selects multidrop mode, 0 selects parity mode |
| len_sel | input | 2 | Data length: 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8 |
| par_odd | input | 1 | Parity sense in normal mode: 1 is odd, 0 is even |
| pop | input | 1 | Removes the head character |
| rd_data | output | 8 | Head character data |
| rd_status | output | 8 | Bit 7 break, bit 6 framing, bit 5 tag or parity error, bit 4 sticky overrun; bits 3 to 0 are 0 |
| rx_rdy | output | 1 | The queue holds at least one character |

## Verification
A character reaches the queue a few clocks after the middle of its stop bit. The delay is two synchronizer flops, up to one tick of start-detection jitter, one registered done pulse and one queue write. The bench therefore reads `rx_rdy`, `rd_data` and `rd_status` only after the full stop bit and two idle bit times have been driven. A pop takes effect at the next rising edge, so the bench checks the new head or the empty flag on the following falling edge. All inputs are driven, and all outputs sampled, on falling edges.

// File: rtl/mdr_pkg.sv
package mdr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_BITS, S_STOP, S_WAITHI
  } rx_state_e;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       s5;
    logic [7:0] data;
  } rx_char_t;
endpackage

// File: rtl/mdr_tick.sv
module mdr_tick #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_d;

  always_comb begin
    tick_d = (cnt_q == CW'(TICK_DIV - 1));
    cnt_d  = tick_d ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = tick_d;

  generate
    if (TICK_DIV > 1) begin : g_gap_chk
      p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/mdr_frame.sv
module mdr_frame
  import mdr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] len_sel,
  output logic       done,
  output logic [7:0] data,
  output logic       tag,
  output logic       stop
);
  logic [1:0] sync_q;
  logic       rx_s;
  rx_state_e  st_q, st_d;
  logic [3:0] cnt_q, cnt_d;
  logic [3:0] idx_q, idx_d;
  logic [7:0] data_q, data_d;
  logic       tag_q, tag_d, stop_q, stop_d, done_q, done_d;
  logic [3:0] last_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end
  assign rx_s     = sync_q[1];
  assign last_idx = 4'd5 + {2'b00, len_sel};

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    data_d = data_q;
    tag_d  = tag_q;
    stop_d = stop_q;
    done_d = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (tick && !rx_s) begin
          st_d  = S_START;
          cnt_d = '0;
        end
      end
      S_START: begin
        if (tick) begin
          if (cnt_q == 4'd7) begin
            if (!rx_s) begin
              st_d   = S_BITS;
              cnt_d  = '0;
              idx_d  = '0;
              data_d = '0;
              tag_d  = 1'b0;
            end else begin
              st_d = S_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      S_BITS: begin
        if (tick) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == 4'd15) begin
            if (idx_q == last_idx) begin
              tag_d = rx_s;
              st_d  = S_STOP;
            end else begin
              data_d[idx_q[2:0]] = rx_s;
            end
            idx_d = idx_q + 1'b1;
          end
        end
      end
      S_STOP: begin
        if (tick) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == 4'd15) begin
            stop_d = rx_s;
            done_d = 1'b1;
            st_d   = rx_s ? S_IDLE : S_WAITHI;
          end
        end
      end
      S_WAITHI: begin
        if (rx_s) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      data_q <= '0;
      tag_q  <= 1'b0;
      stop_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      data_q <= data_d;
      tag_q  <= tag_d;
      stop_q <= stop_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign data = data_q;
  assign tag  = tag_q;
  assign stop = stop_q;

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_low_stop_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !stop_q) |-> (st_q == S_WAITHI));
  p_start_checked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_START && tick && cnt_q == 4'd7 && rx_s) |=> (st_q == S_IDLE));
endmodule

// File: rtl/mdr_fifo.sv
module mdr_fifo
  import mdr_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  rx_char_t din,
  input  logic     pop,
  output rx_char_t dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic     full,
  output logic     ovr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rx_char_t      mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovr_q, ovr_d;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full    = (cnt_q == CW'(DEPTH));
    do_pop  = pop && (cnt_q != '0);
    do_push = push && (!full || do_pop);
    wp_d    = do_push ? ptr_inc(wp_q) : wp_q;
    rp_d    = do_pop  ? ptr_inc(rp_q) : rp_q;
    cnt_d   = cnt_q;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    ovr_d   = ovr_q | (push && full && !pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign count = cnt_q;
  assign ovr   = ovr_q;

  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !push) |=> (cnt_q == '0));
  p_ovr_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> ovr_q);
  p_ovr_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);
endmodule

// File: rtl/mdr_rx_top.sv
module mdr_rx_top
  import mdr_pkg::*;
#(
  parameter int TICK_DIV   = 4,
  parameter int FIFO_DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       rx_en,
  input  logic       mdrop,
  input  logic [1:0] len_sel,
  input  logic       par_odd,
  input  logic       pop,
  output logic [7:0] rd_data,
  output logic [7:0] rd_status,
  output logic       rx_rdy
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [1:0]    rs_q;
  logic          rst_s_n;
  logic          tick, done, tag, stop;
  logic [7:0]    data;
  logic          accept, push, par_err;
  rx_char_t      ch_in, ch_out;
  logic [CW-1:0] fcount;
  logic          ffull, fovr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  mdr_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_s_n), .tick(tick)
  );

  mdr_frame u_frame (
    .clk(clk), .rst_n(rst_s_n), .tick(tick), .rxd(rxd), .len_sel(len_sel),
    .done(done), .data(data), .tag(tag), .stop(stop)
  );

  always_comb begin
    par_err    = (^{data, tag}) ^ par_odd;
    accept     = mdrop ? (rx_en | tag) : rx_en;
    push       = done & accept;
    ch_in.data = data;
    ch_in.s5   = mdrop ? tag : par_err;
    ch_in.ferr = ~stop;
    ch_in.brk  = ~stop & ~tag & (data == 8'h00);
  end

  mdr_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_s_n), .push(push), .din(ch_in), .pop(pop),
    .dout(ch_out), .count(fcount), .full(ffull), .ovr(fovr)
  );

  assign rd_data   = ch_out.data;
  assign rd_status = {ch_out.brk, ch_out.ferr, ch_out.s5, fovr, 4'b0000};
  assign rx_rdy    = (fcount != '0);

  p_drop_data_tag_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done && mdrop && !rx_en && !tag && !pop) |=> $stable(fcount));
  p_take_all_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done && mdrop && rx_en && !ffull) |=> (fcount != '0));
  p_normal_off_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done && !mdrop && !rx_en && !pop) |=> $stable(fcount));
endmodule

// File: tb/sim_mdr_rx_top.sv
module sim_mdr_rx_top;
  localparam int DIV = 4;
  localparam int BIT = 16 * DIV;

  logic       clk, rst_n, rxd, rx_en, mdrop, par_odd, pop;
  logic [1:0] len_sel;
  logic [7:0] rd_data, rd_status;
  logic       rx_rdy;
  int         n_chk, n_bad;
  bit         done_run;

  mdr_rx_top #(.TICK_DIV(DIV), .FIFO_DEPTH(3)) u0 (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_en(rx_en), .mdrop(mdrop),
    .len_sel(len_sel), .par_odd(par_odd), .pop(pop),
    .rd_data(rd_data), .rd_status(rd_status), .rx_rdy(rx_rdy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int nb, input logic [7:0] d, input logic tg, input logic sp);
    rxd = 1'b0; wait_clk(BIT);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; wait_clk(BIT); end
    rxd = tg; wait_clk(BIT);
    rxd = sp; wait_clk(BIT);
    rxd = 1'b1; wait_clk(2 * BIT);
  endtask

  task automatic do_pop();
    pop = 1'b1; wait_clk(1);
    pop = 1'b0; wait_clk(1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wait_clk(3);
    rst_n = 1'b1; wait_clk(4);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_run) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done_run = 0;
    rxd = 1'b1; rx_en = 0; mdrop = 0; par_odd = 0; pop = 0; len_sel = 2'd3;
    do_reset();
    check("R1 rdy", int'(rx_rdy), 0);
    check("R1 ovr", int'(rd_status[4]), 0);

    // Sweep of modes, lengths, tags and parity sense
    for (int md = 0; md < 2; md++)
      for (int en = 0; en < 2; en++)
        for (int po = 0; po < 2; po++)
          for (int ls = 0; ls < 4; ls++)
            for (int tg = 0; tg < 2; tg++) begin
              int nb, mask, d, acc, s5;
              string rq;
              nb = 5 + ls; mask = (1 << nb) - 1;
              d = ((md * 16 + en * 8 + po * 4 + ls) * 29 + tg * 7 + 11) & mask;
              mdrop = md[0]; rx_en = en[0]; par_odd = po[0]; len_sel = ls[1:0];
              wait_clk(1);
              send(nb, d[7:0], tg[0], 1'b1);
              if (md == 1) begin
                acc = (en == 1 || tg == 1) ? 1 : 0;
                s5 = tg;
                rq = (en == 1) ? "R5" : ((tg == 1) ? "R3" : "R4");
              end else begin
                acc = en;
                s5 = ($countones(d) + tg + po) & 1;
                rq = "R6";
              end
              check(rq, int'(rx_rdy), acc);
              if (acc == 1) begin
                check("R2 data", int'(rd_data), d);
                check(md == 1 ? "R3/R5 status" : "R7 parity", int'(rd_status), s5 << 5);
                do_pop();
                check("R10 empty after pop", int'(rx_rdy), 0);
              end
            end

    // Framing error
    mdrop = 1; rx_en = 1; len_sel = 2'd3; wait_clk(1);
    send(8, 8'h5C, 1'b1, 1'b0);
    check("R8 rdy", int'(rx_rdy), 1);
    check("R8 data", int'(rd_data), 'h5C);
    check("R8 status", int'(rd_status), 'h60);
    do_pop();

    // Break: long low then high
    rxd = 1'b0; wait_clk(14 * BIT);
    rxd = 1'b1; wait_clk(3 * BIT);
    check("R9 rdy", int'(rx_rdy), 1);
    check("R9 data", int'(rd_data), 0);
    check("R9 status", int'(rd_status), 'hC0);
    do_pop();
    check("R9 single char", int'(rx_rdy), 0);
    send(8, 8'hA5, 1'b0, 1'b1);
    check("R9 recover data", int'(rd_data), 'hA5);
    do_pop();

    // Short glitch
    rxd = 1'b0; wait_clk(4 * DIV);
    rxd = 1'b1; wait_clk(2 * BIT);
    check("R12 glitch", int'(rx_rdy), 0);
    send(8, 8'h3C, 1'b1, 1'b1);
    check("R12 after glitch", int'(rd_data), 'h3C);
    do_pop();

    // Pop on empty queue
    do_pop(); do_pop();
    check("R10 empty pop", int'(rx_rdy), 0);
    send(8, 8'h5A, 1'b0, 1'b1);
    check("R10 rdy", int'(rx_rdy), 1);
    check("R10 data", int'(rd_data), 'h5A);
    do_pop();
    check("R10 empty", int'(rx_rdy), 0);

    // Fill, overrun, ordering
    send(8, 8'h11, 1'b0, 1'b1);
    send(8, 8'h22, 1'b1, 1'b1);
    send(8, 8'h33, 1'b0, 1'b1);
    check("R11 no ovr yet", int'(rd_status[4]), 0);
    send(8, 8'h44, 1'b1, 1'b1);
    check("R11 ovr set", int'(rd_status[4]), 1);
    check("R10 order 1", int'(rd_data), 'h11);
    do_pop();
    check("R10 order 2", int'(rd_data), 'h22);
    check("R11 status", int'(rd_status), 'h30);
    do_pop();
    check("R10 order 3", int'(rd_data), 'h33);
    do_pop();
    check("R11 discarded", int'(rx_rdy), 0);
    check("R11 sticky", int'(rd_status[4]), 1);

    do_reset();
    check("R1 ovr cleared", int'(rd_status[4]), 0);
    check("R1 rdy", int'(rx_rdy), 0);

    done_run = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule